// File: doc/BRIEF.md
# SDRAM Controller Configuration Register Unit

This block is the software-visible configuration front end of a small SDRAM controller. Software reaches every register through two bus locations. The selector location holds a register index. The window location reads or writes whichever register that index points at. The unit holds the global controller configuration and a read-only status word. It also holds refresh, timing, power-management and ECC settings, bus-error capture registers, an ECC error status word and one configuration word per bank.

From the bank words the unit derives a base, a size and an active flag for each bank. It also compares a probe address against all active banks and reports which bank the address falls in. The lowest-numbered bank wins when windows overlap. The ECC error status word drives an interrupt line that is high exactly while that word is non-zero. Writes take effect on the rising clock edge. Reads are combinational from the current index.

Top module: `sdram_cfg_regs`

## Requirements
- R1: A write with `bus_sel`=0 stores the full 32-bit index. A read with `bus_sel`=0 returns the stored index, which is 0 after reset.
- R2: After reset the window reads configuration (index 0x20) 0x00800000, refresh (0x30) 0x05F00000, power-management (0x34) 0x07C00000, and status (0x24), bank words (0x40/0x44/0x48/0x4C) and ECC error status (0x98) all 0. `ecc_irq_o` is low.
- R3: A write to bank word i (index 0x40+4*i) stores only the bits of mask 0xFFDEE001.
- R4: A configuration write (0x20) stores only bits 31:21. When bit 31 changes from 0 to 1, status bit 31 is cleared. When bit 31 changes from 1 to 0, status bit 31 is set.
- R5: Status bit 30 is set when configuration bit 30 changes from 0 to 1 and cleared when it changes from 1 to 0. It is otherwise held.
- R6: Writes to the status index (0x24) have no effect on the status value.
- R7: Refresh writes keep mask 0x3FF80000 and ECC configuration writes (0x94) keep 0x00F00000. Timing writes (0x80) keep 0x018FC01F, which appears on `timing_o` (reset 0x00854009). Reading the timing index returns 0xFFFFFFFF.
- R8: A power-management write keeps bits 31:27, and the register reads back with 0x07C00000 ORed in.
- R9: Error status words 0x00 and 0x08 are write-one-to-clear and read 0 when nothing has set them. The error address (0x10) stores the full written word.
- R10: An ECC error status write (0x98) keeps mask 0xFFF0F000. `ecc_irq_o` rises on the edge after a write that makes the word non-zero and falls on the edge after a write that makes it zero.
- R11: A window read of any index not listed above returns 0xFFFFFFFF.
- R12: For bank i, `bank_base_o` is word bits 31:23 followed by 23 zero bits, and `bank_size_o` is 4 MiB shifted left by the code in bits 19:17, or 0 for code 7. `bank_en_o[i]` is configuration bit 31 AND word bit 0 AND code not 7.
- R13: `hit_o` is high when some active bank satisfies base <= `probe_addr` < base+size. `hit_bank_o` gives the lowest such bank number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | 0 selects the index location, 1 the data window |
| bus_wr | input | 1 | Write strobe for the selected location |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data of the selected location |
| probe_addr | input | 32 | Address to decode against the banks |
| hit_o | output | 1 | Probe address falls in an active bank |
| hit_bank_o | output | 2 | Lowest-numbered matching bank |
| bank_en_o | output | 4 | Per-bank active flag |
| bank_base_o | output | 128 | Per-bank base address, bank i at bits 32*i+31:32*i |
| bank_size_o | output | 128 | Per-bank size in bytes, same packing |
| timing_o | output | 32 | Stored timing word |
| ecc_irq_o | output | 1 | ECC error interrupt |

## Verification
The configuration word is driven through a sequence of values chosen so that bit 31 and bit 30 rise and fall both separately and together. This separates edge-triggered status updates from plain copies of the configuration bits. Every masked register receives all ones, which exposes a wrong mask bit in either direction. Bank decode uses a small window, a larger overlapping one, a gap between windows and a code-7 bank. Probes sit on the first and last byte of each window and one byte past it, so off-by-one bounds and wrong priority give different bank numbers. The ECC word is written zero to non-zero, non-zero to non-zero, and back to zero, which shows the interrupt tracks the value rather than the write strobe.

// File: rtl/sdram_cfg_pkg.sv
package sdram_cfg_pkg;
   localparam int unsigned WORD_W = 32;

   // index codes seen through the selector location
   localparam logic [31:0] IX_BERR0  = 32'h0000_0000;
   localparam logic [31:0] IX_BERR1  = 32'h0000_0008;
   localparam logic [31:0] IX_BADDR  = 32'h0000_0010;
   localparam logic [31:0] IX_GCFG   = 32'h0000_0020;
   localparam logic [31:0] IX_GSTAT  = 32'h0000_0024;
   localparam logic [31:0] IX_RFSH   = 32'h0000_0030;
   localparam logic [31:0] IX_PWR    = 32'h0000_0034;
   localparam logic [31:0] IX_BANK0  = 32'h0000_0040;
   localparam logic [31:0] IX_TIMING = 32'h0000_0080;
   localparam logic [31:0] IX_ECFG   = 32'h0000_0094;
   localparam logic [31:0] IX_ESTAT  = 32'h0000_0098;

   localparam logic [31:0] MSK_BANK  = 32'hFFDE_E001;
   localparam logic [31:0] MSK_GCFG  = 32'hFFE0_0000;
   localparam logic [31:0] MSK_RFSH  = 32'h3FF8_0000;
   localparam logic [31:0] MSK_TIM   = 32'h018F_C01F;
   localparam logic [31:0] MSK_ECFG  = 32'h00F0_0000;
   localparam logic [31:0] MSK_ESTAT = 32'hFFF0_F000;
   localparam logic [31:0] MSK_PWR   = 32'hF800_0000;
   localparam logic [31:0] PWR_FIXED = 32'h07C0_0000;

   localparam logic [31:0] RST_GCFG  = 32'h0080_0000;
   localparam logic [31:0] RST_RFSH  = 32'h05F0_0000;
   localparam logic [31:0] RST_TIM   = 32'h0085_4009;

   localparam logic [31:0] MIN_BANK_BYTES = 32'h0040_0000;

   function automatic logic [31:0] bank_index(input int unsigned b);
      return IX_BANK0 + 32'(4 * b);
   endfunction
endpackage

// File: rtl/sdram_cfg_regfile.sv
module sdram_cfg_regfile
   import sdram_cfg_pkg::*;
#(
   parameter int unsigned NBANK = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   bus_sel,
   input  logic                   bus_wr,
   input  logic [31:0]            bus_wdata,
   output logic [31:0]            bus_rdata,
   output logic [31:0]            gcfg_o,
   output logic [NBANK-1:0][31:0] bank_word_o,
   output logic [31:0]            timing_o,
   output logic                   irq_o
);
   logic [31:0] idx_q, berr0_q, berr1_q, baddr_q, gcfg_q, gstat_q;
   logic [31:0] rfsh_q, pwr_q, tim_q, ecfg_q, estat_q;
   logic [NBANK-1:0][31:0] bank_q;
   logic        irq_q;

   logic win_wr;
   logic [31:0] gcfg_nx, estat_nx;
   assign win_wr   = bus_wr & bus_sel;
   assign gcfg_nx  = bus_wdata & MSK_GCFG;
   assign estat_nx = bus_wdata & MSK_ESTAT;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q   <= '0;
         berr0_q <= '0;
         berr1_q <= '0;
         baddr_q <= '0;
         gcfg_q  <= RST_GCFG;
         gstat_q <= '0;
         rfsh_q  <= RST_RFSH;
         pwr_q   <= PWR_FIXED;
         tim_q   <= RST_TIM;
         ecfg_q  <= '0;
         estat_q <= '0;
         irq_q   <= 1'b0;
         bank_q  <= '0;
      end else begin
         if (bus_wr && !bus_sel) idx_q <= bus_wdata;
         if (win_wr) begin
            case (idx_q)
               IX_BERR0:  berr0_q <= berr0_q & ~bus_wdata;
               IX_BERR1:  berr1_q <= berr1_q & ~bus_wdata;
               IX_BADDR:  baddr_q <= bus_wdata;
               IX_GCFG: begin
                  gcfg_q <= gcfg_nx;
                  if (!gcfg_q[31] && gcfg_nx[31]) gstat_q[31] <= 1'b0;
                  else if (gcfg_q[31] && !gcfg_nx[31]) gstat_q[31] <= 1'b1;
                  if (!gcfg_q[30] && gcfg_nx[30]) gstat_q[30] <= 1'b1;
                  else if (gcfg_q[30] && !gcfg_nx[30]) gstat_q[30] <= 1'b0;
               end
               IX_RFSH:   rfsh_q <= bus_wdata & MSK_RFSH;
               IX_PWR:    pwr_q  <= (bus_wdata & MSK_PWR) | PWR_FIXED;
               IX_TIMING: tim_q  <= bus_wdata & MSK_TIM;
               IX_ECFG:   ecfg_q <= bus_wdata & MSK_ECFG;
               IX_ESTAT: begin
                  estat_q <= estat_nx;
                  irq_q   <= (estat_nx != '0);
               end
               default: ;
            endcase
            for (int b = 0; b < NBANK; b++)
               if (idx_q == bank_index(b)) bank_q[b] <= bus_wdata & MSK_BANK;
         end
      end
   end

   always_comb begin
      bus_rdata = '1;
      if (!bus_sel) begin
         bus_rdata = idx_q;
      end else begin
         case (idx_q)
            IX_BERR0: bus_rdata = berr0_q;
            IX_BERR1: bus_rdata = berr1_q;
            IX_BADDR: bus_rdata = baddr_q;
            IX_GCFG:  bus_rdata = gcfg_q;
            IX_GSTAT: bus_rdata = gstat_q;
            IX_RFSH:  bus_rdata = rfsh_q;
            IX_PWR:   bus_rdata = pwr_q;
            IX_ECFG:  bus_rdata = ecfg_q;
            IX_ESTAT: bus_rdata = estat_q;
            default:  bus_rdata = '1;
         endcase
         for (int b = 0; b < NBANK; b++)
            if (idx_q == bank_index(b)) bus_rdata = bank_q[b];
      end
   end

   assign gcfg_o      = gcfg_q;
   assign bank_word_o = bank_q;
   assign timing_o    = tim_q;
   assign irq_o       = irq_q;

   // R4: disabling the controller flags status bit 31
   p_disable_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (win_wr && idx_q == IX_GCFG && gcfg_q[31] && !bus_wdata[31]) |=> gstat_q[31]);
   // R6: status location ignores writes
   p_status_ro_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (win_wr && idx_q == IX_GSTAT) |=> $stable(gstat_q));
   // R10: interrupt only moves after an ECC status write
   p_irq_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_q) |-> $past(win_wr && idx_q == IX_ESTAT));
   p_irq_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_q) |-> $past(win_wr && idx_q == IX_ESTAT));
endmodule

// File: rtl/sdram_bank_dec.sv
module sdram_bank_dec
   import sdram_cfg_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic [31:0]       word_i,
   input  logic              glob_en_i,
   input  logic [ADDR_W-1:0] probe_i,
   output logic [31:0]       base_o,
   output logic [31:0]       size_o,
   output logic              active_o,
   output logic              match_o
);
   localparam int unsigned SUM_W = ADDR_W + 1;
   logic [2:0]       code;
   logic             code_ok;
   logic [SUM_W-1:0] lo, hi, pa;

   assign code    = word_i[19:17];
   assign code_ok = (code != 3'd7);
   assign base_o  = {word_i[31:23], 23'd0};
   assign size_o  = code_ok ? (MIN_BANK_BYTES << code) : 32'd0;
   assign active_o = glob_en_i & word_i[0] & code_ok;

   assign lo = SUM_W'(base_o);
   assign hi = SUM_W'(base_o) + SUM_W'(size_o);
   assign pa = SUM_W'(probe_i);
   assign match_o = active_o && (pa >= lo) && (pa < hi);
endmodule

// File: rtl/sdram_bank_prio.sv
module sdram_bank_prio #(
   parameter int unsigned NBANK = 4,
   localparam int unsigned IDXW = (NBANK > 1) ? $clog2(NBANK) : 1
) (
   input  logic [NBANK-1:0] match_i,
   output logic             hit_o,
   output logic [IDXW-1:0]  bank_o
);
   always_comb begin
      bank_o = '0;
      for (int b = NBANK - 1; b >= 0; b--)
         if (match_i[b]) bank_o = IDXW'(b);
   end
   assign hit_o = |match_i;
endmodule

// File: rtl/sdram_cfg_regs.sv
module sdram_cfg_regs
   import sdram_cfg_pkg::*;
#(
   parameter int unsigned NBANK  = 4,
   parameter int unsigned ADDR_W = 32,
   localparam int unsigned IDXW  = (NBANK > 1) ? $clog2(NBANK) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_sel,
   input  logic                bus_wr,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   input  logic [ADDR_W-1:0]   probe_addr,
   output logic                hit_o,
   output logic [IDXW-1:0]     hit_bank_o,
   output logic [NBANK-1:0]    bank_en_o,
   output logic [NBANK*32-1:0] bank_base_o,
   output logic [NBANK*32-1:0] bank_size_o,
   output logic [31:0]         timing_o,
   output logic                ecc_irq_o
);
   generate
      if (NBANK < 1 || NBANK > 4) begin : g_bad_nbank
         $error("NBANK must lie in 1..4, index map has four bank slots");
      end
      if (ADDR_W != 32) begin : g_bad_addr
         $error("ADDR_W must be 32 to match the base field layout");
      end
   endgenerate

   logic [31:0]            gcfg;
   logic [NBANK-1:0][31:0] bank_word;
   logic [NBANK-1:0]       match;

   sdram_cfg_regfile #(.NBANK(NBANK)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_sel     (bus_sel),
      .bus_wr      (bus_wr),
      .bus_wdata   (bus_wdata),
      .bus_rdata   (bus_rdata),
      .gcfg_o      (gcfg),
      .bank_word_o (bank_word),
      .timing_o    (timing_o),
      .irq_o       (ecc_irq_o)
   );

   for (genvar g = 0; g < NBANK; g++) begin : g_bank
      sdram_bank_dec #(.ADDR_W(ADDR_W)) u_dec (
         .word_i    (bank_word[g]),
         .glob_en_i (gcfg[31]),
         .probe_i   (probe_addr),
         .base_o    (bank_base_o[g*32 +: 32]),
         .size_o    (bank_size_o[g*32 +: 32]),
         .active_o  (bank_en_o[g]),
         .match_o   (match[g])
      );
   end

   sdram_bank_prio #(.NBANK(NBANK)) u_prio (
      .match_i (match),
      .hit_o   (hit_o),
      .bank_o  (hit_bank_o)
   );

   // R12: no bank is active while the controller is disabled
   p_en_needs_global_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (|bank_en_o) |-> gcfg[31]);
   // R13: a reported bank is always an active one
   p_hit_active_r13: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |-> bank_en_o[hit_bank_o]);
endmodule

// File: tb/sdram_cfg_regs_tb.sv
module sdram_cfg_regs_tb;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bus_sel = 1'b0, bus_wr = 1'b0;
   logic [31:0]  bus_wdata = '0, bus_rdata;
   logic [31:0]  probe_addr = '0;
   logic         hit_o, ecc_irq_o;
   logic [1:0]   hit_bank_o;
   logic [3:0]   bank_en_o;
   logic [127:0] bank_base_o, bank_size_o;
   logic [31:0]  timing_o;
   int n_run = 0, n_fail = 0;
   bit done = 0;

   always #4 clk = ~clk;

   sdram_cfg_regs u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .probe_addr(probe_addr),
      .hit_o(hit_o), .hit_bank_o(hit_bank_o), .bank_en_o(bank_en_o),
      .bank_base_o(bank_base_o), .bank_size_o(bank_size_o),
      .timing_o(timing_o), .ecc_irq_o(ecc_irq_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic sel, input logic [31:0] d);
      @(negedge clk);
      bus_sel = sel; bus_wr = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic put(input logic [31:0] ix, input logic [31:0] d);
      wr(1'b0, ix);
      wr(1'b1, d);
   endtask

   task automatic get(input logic [31:0] ix, output logic [31:0] d);
      wr(1'b0, ix);
      bus_sel = 1'b1;
      #1 d = bus_rdata;
   endtask

   task automatic t_reset;
      logic [31:0] v;
      bus_sel = 1'b0; #1 chk("R1 index reset", bus_rdata, 32'h0);
      get(32'h20, v); chk("R2 cfg reset", v, 32'h0080_0000);
      get(32'h30, v); chk("R2 refresh reset", v, 32'h05F0_0000);
      get(32'h34, v); chk("R2 pwr reset", v, 32'h07C0_0000);
      get(32'h24, v); chk("R2 status reset", v, 32'h0);
      get(32'h44, v); chk("R2 bank1 reset", v, 32'h0);
      get(32'h98, v); chk("R2 ecc status reset", v, 32'h0);
      chk("R2 irq reset", {31'd0, ecc_irq_o}, 32'h0);
      chk("R7 timing reset", timing_o, 32'h0085_4009);
   endtask

   task automatic t_index;
      wr(1'b0, 32'hDEAD_BEEF);
      bus_sel = 1'b0; #1 chk("R1 index readback", bus_rdata, 32'hDEAD_BEEF);
   endtask

   task automatic t_cfg_status;
      logic [31:0] v;
      put(32'h20, 32'h8000_0000);
      get(32'h24, v); chk("R4 enable clears st31", v, 32'h0);
      put(32'h20, 32'h0000_0000);
      get(32'h24, v); chk("R4 disable sets st31", v, 32'h8000_0000);
      put(32'h20, 32'h4000_0000);
      get(32'h24, v); chk("R5 bit30 rise", v, 32'hC000_0000);
      put(32'h20, 32'hFFFF_FFFF);
      get(32'h20, v); chk("R4 cfg mask", v, 32'hFFE0_0000);
      get(32'h24, v); chk("R4 R5 both high", v, 32'h4000_0000);
      put(32'h24, 32'h0000_0000);
      get(32'h24, v); chk("R6 status write ignored", v, 32'h4000_0000);
      put(32'h20, 32'h0000_0000);
      get(32'h24, v); chk("R5 bit30 fall with R4", v, 32'h8000_0000);
   endtask

   task automatic t_masks;
      logic [31:0] v;
      put(32'h30, 32'hFFFF_FFFF); get(32'h30, v); chk("R7 refresh mask", v, 32'h3FF8_0000);
      put(32'h94, 32'hFFFF_FFFF); get(32'h94, v); chk("R7 ecc cfg mask", v, 32'h00F0_0000);
      put(32'h80, 32'hFFFF_FFFF); get(32'h80, v); chk("R7 timing reads ones", v, 32'hFFFF_FFFF);
      chk("R7 timing mask", timing_o, 32'h018F_C01F);
      put(32'h34, 32'h0000_0000); get(32'h34, v); chk("R8 pwr low forced", v, 32'h07C0_0000);
      put(32'h34, 32'hFFFF_FFFF); get(32'h34, v); chk("R8 pwr high kept", v, 32'hFFC0_0000);
      put(32'h00, 32'hFFFF_FFFF); get(32'h00, v); chk("R9 err0 w1c", v, 32'h0);
      put(32'h08, 32'h1234_5678); get(32'h08, v); chk("R9 err1 w1c", v, 32'h0);
      put(32'h10, 32'hA5A5_1234); get(32'h10, v); chk("R9 err addr", v, 32'hA5A5_1234);
      get(32'h04, v); chk("R11 unknown", v, 32'hFFFF_FFFF);
      get(32'h50, v); chk("R11 unknown past banks", v, 32'hFFFF_FFFF);
   endtask

   task automatic t_ecc;
      logic [31:0] v;
      put(32'h98, 32'h000F_0FFF);
      get(32'h98, v); chk("R10 ecc mask to zero", v, 32'h0);
      chk("R10 irq stays low", {31'd0, ecc_irq_o}, 32'h0);
      put(32'h98, 32'hFFFF_FFFF);
      chk("R10 irq rises", {31'd0, ecc_irq_o}, 32'h1);
      get(32'h98, v); chk("R10 ecc mask", v, 32'hFFF0_F000);
      put(32'h98, 32'h0000_1000);
      chk("R10 irq holds", {31'd0, ecc_irq_o}, 32'h1);
      put(32'h98, 32'h0);
      chk("R10 irq falls", {31'd0, ecc_irq_o}, 32'h0);
   endtask

   task automatic probe(input logic [31:0] a, input logic h, input logic [1:0] b, input string tag);
      probe_addr = a;
      #1;
      chk({tag, " hit"}, {31'd0, hit_o}, {31'd0, h});
      if (h) chk({tag, " bank"}, {30'd0, hit_bank_o}, {30'd0, b});
   endtask

   task automatic t_banks;
      logic [31:0] v;
      put(32'h40, 32'h0000_0001);
      put(32'h44, 32'h0082_0001);
      put(32'h48, 32'h0084_0001);
      put(32'h4C, 32'hFFFF_FFFF);
      get(32'h4C, v); chk("R3 bank mask", v, 32'hFFDE_E001);
      chk("R12 en while global off", {28'd0, bank_en_o}, 32'h0);
      probe(32'h0000_0000, 1'b0, 2'd0, "R13 global off");
      put(32'h20, 32'h8000_0000);
      chk("R12 en vector", {28'd0, bank_en_o}, 32'h7);
      chk("R12 base1", bank_base_o[63:32], 32'h0080_0000);
      chk("R12 size2", bank_size_o[95:64], 32'h0100_0000);
      chk("R12 size code7", bank_size_o[127:96], 32'h0);
      chk("R12 base3", bank_base_o[127:96], 32'hFF80_0000);
      probe(32'h003F_FFFF, 1'b1, 2'd0, "R13 bank0 top");
      probe(32'h0040_0000, 1'b0, 2'd0, "R13 gap");
      probe(32'h0080_0000, 1'b1, 2'd1, "R13 overlap low wins");
      probe(32'h00FF_FFFF, 1'b1, 2'd1, "R13 bank1 top");
      probe(32'h0100_0000, 1'b1, 2'd2, "R13 bank2 only");
      probe(32'h017F_FFFF, 1'b1, 2'd2, "R13 bank2 top");
      probe(32'h0180_0000, 1'b0, 2'd0, "R13 past bank2");
      probe(32'hFF80_0000, 1'b0, 2'd0, "R13 code7 bank");
      put(32'h40, 32'h0000_0000);
      probe(32'h0000_0010, 1'b0, 2'd0, "R12 bank0 disabled");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_index();
      t_cfg_status();
      t_masks();
      t_ecc();
      t_banks();
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule